// File: doc/BRIEF.md
# Clock-Manager Reset and Lock Sequencer

This block brings up a chain of clock-synthesis units and keeps it running. The chain has one master and a parameterised number of slaves that depend on it. The sequencer runs on a free-running reference clock that none of these units produces. It drives one reset line per unit and reads each unit's lock flag and status flags through two-flop synchronizers. It also runs a watchdog on the raw input clock that feeds the master.

Start-up is staged. The master is reset first. Once the master has locked, every slave begins its own reset-and-wait sequence. A unit whose feedback path runs off chip gets a longer reset hold than a unit with internal feedback. A unit that does not lock within the timeout is reset again.

The downstream system reset is held until every unit has stayed locked for a settle period. Any failure puts the chain back into reset and starts it again, with no outside help. A failure here is a lost lock, a stopped-clock status flag, a bad slave status or a missing input clock.

Top module: `clkmgr_rst_seq`

## Requirements
- R1: While `rst_n` is low, every unit reset output is 1 and `sys_rst_n` is 0. Every reset pulse sent to a unit lasts at least 3 reference cycles, and never less than that unit's configured hold length.
- R2: No slave reset is released while the master is not in its locked state. Slaves start their sequence only after the master has locked.
- R3: A unit marked as using external feedback holds reset for `LONG_RST` cycles and an internally fed unit for `SHORT_RST` cycles. For two slaves started together, the releases of their resets are exactly `LONG_RST - SHORT_RST` cycles apart.
- R4: If a unit does not report lock within `LOCK_TIMEOUT` cycles after its reset is released, its reset is asserted again, so the reset output rises repeatedly.
- R5: The master is reset again when its lock flag drops, or when its input-stopped or synthesized-stopped status flag (1 = stopped) is seen while it is locked.
- R6: A locked slave that loses lock or raises its bad-status flag (1 = bad) restarts the whole chain, beginning with a new master reset.
- R7: The master reset stays asserted while no input-clock edge has been seen within `WDOG_WIN` reference cycles, and also after reset until a first edge has been seen.
- R8: After the input clock is removed and then reapplied, the chain returns to the all-locked state and `sys_rst_n` goes back to 1 with no outside action.
- R9: `sys_rst_n` (1 = system out of reset) rises only after all units have been locked for at least `SETTLE` consecutive cycles. It is 1 only while no unit reset is asserted. The lock and status inputs pass through two synchronizer flops, so the rise comes between `SETTLE+2` and `SETTLE+6` cycles after the last lock input rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock for the sequencer |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_clk | input | 1 | Input clock of the master, watched for activity |
| mst_locked | input | 1 | Master lock flag (asynchronous) |
| mst_in_stopped | input | 1 | Master status: input clock stopped (asynchronous) |
| mst_fx_stopped | input | 1 | Master status: synthesized clock stopped (asynchronous) |
| slv_locked | input | NUM_SLV | Lock flag of each slave (asynchronous) |
| slv_bad | input | NUM_SLV | Bad-status flag of each slave (asynchronous) |
| mst_rst | output | 1 | Reset to the master, active high |
| slv_rst | output | NUM_SLV | Reset to each slave, active high |
| sys_rst_n | output | 1 | System reset, active low, released once everything is settled |

## Verification
The bench builds the block with two slaves, where only the second uses external feedback. It uses a short hold of 4 and a long hold of 12, a lock timeout of 40, a watchdog window of 16 and a settle count of 8. These small values let a single run show several timeout retries, the exact 8-cycle gap between the two slave reset releases, and the settle delay. They also let the run remove and restore the input clock and still finish quickly. The behavioural unit models lock a programmable number of cycles after their reset falls, so a latency above 40 creates a unit that never locks.

// File: rtl/clkmgr_pkg.sv
package clkmgr_pkg;
  // Per-unit sequencing state
  typedef enum logic [1:0] {
    U_IDLE = 2'd0,   // held in reset, waiting for permission to start
    U_RST  = 2'd1,   // reset asserted, counting the hold length
    U_WAIT = 2'd2,   // reset released, waiting for lock
    U_LOCK = 2'd3    // locked and healthy
  } unit_st_e;
endpackage

// File: rtl/clkmgr_sync2.sv
module clkmgr_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/clkmgr_clk_watch.sv
module clkmgr_clk_watch #(
  parameter int WIN = 32
) (
  input  logic clk,        // reference clock
  input  logic rst_n,      // reference-domain reset
  input  logic mon_clk,    // clock being watched
  input  logic mon_rst_n,  // raw asynchronous reset for the watched domain
  output logic clk_bad
);
  localparam int WW = $clog2(WIN + 1);
  localparam logic [WW-1:0] WIN_V = WW'(WIN);

  logic          tgl_q;
  logic          tgl_s;
  logic          tgl_prev_q;
  logic          edge_seen;
  logic [WW-1:0] gap_q, gap_d;

  // Toggle flag in the watched domain
  always_ff @(posedge mon_clk or negedge mon_rst_n) begin
    if (!mon_rst_n) tgl_q <= 1'b0;
    else            tgl_q <= ~tgl_q;
  end

  clkmgr_sync2 #(.W(1)) u_tgl_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (tgl_q),
    .q    (tgl_s)
  );

  assign edge_seen = tgl_s ^ tgl_prev_q;

  always_comb begin
    gap_d = gap_q;
    if (edge_seen)          gap_d = '0;
    else if (gap_q != WIN_V) gap_d = gap_q + 1'b1;
  end

  // Starts saturated: the clock counts as absent until an edge is seen
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgl_prev_q <= 1'b0;
      gap_q      <= WIN_V;
    end else begin
      tgl_prev_q <= tgl_s;
      gap_q      <= gap_d;
    end
  end

  assign clk_bad = (gap_q == WIN_V);

  // R7: an observed activity edge clears the fault on the next cycle
  a_r7_edge_clears: assert property (@(posedge clk) disable iff (!rst_n)
    edge_seen |=> !clk_bad);
  // R7: the fault only appears after a full quiet window
  a_r7_quiet_window: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_bad) |-> !$past(edge_seen));
endmodule

// File: rtl/clkmgr_unit_seq.sv
module clkmgr_unit_seq
  import clkmgr_pkg::*;
#(
  parameter int HOLD    = 4,
  parameter int TIMEOUT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,     // permission to run the sequence
  input  logic abort,     // forced return to idle
  input  logic lock_s,    // synchronized lock flag
  input  logic bad_s,     // synchronized status fault
  output logic unit_rst,  // registered reset to the unit
  output logic up,        // unit is locked and healthy
  output logic fail       // locked unit has just failed
);
  localparam int MAXC = (HOLD > TIMEOUT) ? HOLD : TIMEOUT;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] HOLD_END = CW'(HOLD - 1);
  localparam logic [CW-1:0] TOUT_END = CW'(TIMEOUT - 1);
  localparam int LW   = $clog2(HOLD + 1) + 1;

  unit_st_e      state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          rst_q, rst_d;

  assign fail = (state_q == U_LOCK) && (!lock_s || bad_s);
  assign up   = (state_q == U_LOCK);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      U_IDLE: begin
        cnt_d = '0;
        if (start && !abort) state_d = U_RST;
      end
      U_RST: begin
        if (cnt_q == HOLD_END) begin
          state_d = U_WAIT;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      U_WAIT: begin
        if (lock_s && !bad_s) begin
          state_d = U_LOCK;
          cnt_d   = '0;
        end else if (cnt_q == TOUT_END) begin
          state_d = U_RST;      // lock timeout: retry the reset
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      U_LOCK: begin
        if (fail) state_d = U_IDLE;
      end
      default: state_d = U_IDLE;
    endcase
    if (!start || abort) begin
      state_d = U_IDLE;
      cnt_d   = '0;
    end
    rst_d = (state_d == U_IDLE) || (state_d == U_RST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= U_IDLE;
      cnt_q   <= '0;
      rst_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      rst_q   <= rst_d;
    end
  end

  assign unit_rst = rst_q;

  // Pulse length monitor for the checks below
  logic [LW-1:0] rst_len_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 rst_len_q <= '0;
    else if (!rst_q)            rst_len_q <= '0;
    else if (rst_len_q != '1)   rst_len_q <= rst_len_q + 1'b1;
  end

  // R1: no reset pulse shorter than three reference cycles
  a_r1_min_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_q) |-> rst_len_q >= LW'(3));
  // R3: each pulse covers at least the configured hold length
  a_r3_hold_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_q) |-> rst_len_q >= LW'(HOLD));
  // R4: a released unit that is still not locked at the timeout is reset again
  a_r4_retry: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == U_WAIT && cnt_q == TOUT_END && !(lock_s && !bad_s)) |=> rst_q);
endmodule

// File: rtl/clkmgr_rst_seq.sv
module clkmgr_rst_seq
  import clkmgr_pkg::*;
#(
  parameter int                 NUM_SLV      = 2,
  parameter int                 SHORT_RST    = 4,
  parameter int                 LONG_RST     = 64,
  parameter int                 LOCK_TIMEOUT = 4096,
  parameter int                 WDOG_WIN     = 32,
  parameter int                 SETTLE       = 256,
  parameter bit                 MST_EXT_FB   = 1'b0,
  parameter logic [NUM_SLV-1:0] SLV_EXT_FB   = '0
) (
  input  logic               ref_clk,
  input  logic               rst_n,
  input  logic               in_clk,
  input  logic               mst_locked,
  input  logic               mst_in_stopped,
  input  logic               mst_fx_stopped,
  input  logic [NUM_SLV-1:0] slv_locked,
  input  logic [NUM_SLV-1:0] slv_bad,
  output logic               mst_rst,
  output logic [NUM_SLV-1:0] slv_rst,
  output logic               sys_rst_n
);
  localparam int SYW = 3 + 2 * NUM_SLV;
  localparam int SW  = $clog2(SETTLE + 1);
  localparam logic [SW-1:0] SETTLE_V = SW'(SETTLE);
  localparam int MST_HOLD = MST_EXT_FB ? LONG_RST : SHORT_RST;

  // Local reset: asserted asynchronously, released on the reference clock
  logic [1:0] rs_q;
  logic       srst_n;
  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  // All unit flags into the reference domain
  logic [SYW-1:0] flags_s;
  clkmgr_sync2 #(.W(SYW)) u_flag_sync (
    .clk  (ref_clk),
    .rst_n(srst_n),
    .d    ({mst_locked, mst_in_stopped, mst_fx_stopped, slv_locked, slv_bad}),
    .q    (flags_s)
  );

  logic               m_lock_s, m_instop_s, m_fxstop_s;
  logic [NUM_SLV-1:0] s_lock_s, s_bad_s;
  assign m_lock_s   = flags_s[SYW-1];
  assign m_instop_s = flags_s[SYW-2];
  assign m_fxstop_s = flags_s[SYW-3];
  assign s_lock_s   = flags_s[2*NUM_SLV-1:NUM_SLV];
  assign s_bad_s    = flags_s[NUM_SLV-1:0];

  // Input clock watchdog
  logic clk_bad;
  clkmgr_clk_watch #(.WIN(WDOG_WIN)) u_watch (
    .clk      (ref_clk),
    .rst_n    (srst_n),
    .mon_clk  (in_clk),
    .mon_rst_n(rst_n),
    .clk_bad  (clk_bad)
  );

  // Chain restart request from any slave failure
  logic               restart_q;
  logic [NUM_SLV-1:0] s_fail, s_up;
  logic               m_up, m_fail;

  clkmgr_unit_seq #(.HOLD(MST_HOLD), .TIMEOUT(LOCK_TIMEOUT)) u_mst (
    .clk     (ref_clk),
    .rst_n   (srst_n),
    .start   (!clk_bad),
    .abort   (restart_q),
    .lock_s  (m_lock_s),
    .bad_s   (m_instop_s || m_fxstop_s),
    .unit_rst(mst_rst),
    .up      (m_up),
    .fail    (m_fail)
  );

  for (genvar gi = 0; gi < NUM_SLV; gi++) begin : g_slv
    localparam int S_HOLD = SLV_EXT_FB[gi] ? LONG_RST : SHORT_RST;
    clkmgr_unit_seq #(.HOLD(S_HOLD), .TIMEOUT(LOCK_TIMEOUT)) u_slv (
      .clk     (ref_clk),
      .rst_n   (srst_n),
      .start   (m_up),
      .abort   (1'b0),
      .lock_s  (s_lock_s[gi]),
      .bad_s   (s_bad_s[gi]),
      .unit_rst(slv_rst[gi]),
      .up      (s_up[gi]),
      .fail    (s_fail[gi])
    );
  end

  always_ff @(posedge ref_clk or negedge srst_n) begin
    if (!srst_n) restart_q <= 1'b0;
    else         restart_q <= |s_fail;
  end

  // Settle counter and system reset
  logic          all_up, drop;
  logic [SW-1:0] set_q, set_d;
  logic          sys_q, sys_d;

  assign all_up = m_up && (&s_up);
  assign drop   = m_fail || (|s_fail) || clk_bad || restart_q;

  always_comb begin
    set_d = set_q;
    if (!all_up || drop)       set_d = '0;
    else if (set_q != SETTLE_V) set_d = set_q + 1'b1;
    sys_d = all_up && !drop && (set_q == SETTLE_V);
  end

  always_ff @(posedge ref_clk or negedge srst_n) begin
    if (!srst_n) begin
      set_q <= '0;
      sys_q <= 1'b0;
    end else begin
      set_q <= set_d;
      sys_q <= sys_d;
    end
  end

  assign sys_rst_n = sys_q;

  // R2: a master that is not locked forces every slave into reset
  a_r2_slave_hold: assert property (@(posedge ref_clk) disable iff (!srst_n)
    !m_up |=> &slv_rst);
  // R6: a slave failure reaches the master reset two cycles later
  a_r6_chain_restart: assert property (@(posedge ref_clk) disable iff (!srst_n)
    (|s_fail) |=> ##1 mst_rst);
  // R7: missing input clock holds the master in reset
  a_r7_master_held: assert property (@(posedge ref_clk) disable iff (!srst_n)
    clk_bad |=> mst_rst);
  // R9: the system leaves reset only when no unit reset is asserted
  a_r9_sys_clean: assert property (@(posedge ref_clk) disable iff (!srst_n)
    sys_rst_n |-> (!mst_rst && !(|slv_rst)));
endmodule

// File: tb/clkmgr_rst_seq_test.sv
module clkmgr_rst_seq_test;
  localparam int NS = 2, SHORT = 4, LONG = 12, TOUT = 40, WIN = 16, SET = 8;

  logic ref_clk = 1'b0;
  logic in_clk  = 1'b0;
  logic clk_en  = 1'b1;
  logic rst_n   = 1'b0;
  logic mst_locked, mst_in_stopped, mst_fx_stopped;
  logic [NS-1:0] slv_locked, slv_bad;
  logic mst_rst, sys_rst_n;
  logic [NS-1:0] slv_rst;

  always #4 ref_clk = ~ref_clk;               // 125 MHz
  initial forever begin #6; if (clk_en) in_clk = ~in_clk; end

  clkmgr_rst_seq #(.NUM_SLV(NS), .SHORT_RST(SHORT), .LONG_RST(LONG),
    .LOCK_TIMEOUT(TOUT), .WDOG_WIN(WIN), .SETTLE(SET),
    .MST_EXT_FB(1'b0), .SLV_EXT_FB(2'b10)) uut (
    .ref_clk(ref_clk), .rst_n(rst_n), .in_clk(in_clk),
    .mst_locked(mst_locked), .mst_in_stopped(mst_in_stopped),
    .mst_fx_stopped(mst_fx_stopped), .slv_locked(slv_locked),
    .slv_bad(slv_bad), .mst_rst(mst_rst), .slv_rst(slv_rst),
    .sys_rst_n(sys_rst_n));

  int checks = 0, errors = 0;
  int m_lat = 5, s_lat[NS];
  int m_cnt = 0, s_cnt[NS];
  bit m_kill = 0;
  int cyc = 0;
  int m_rises = 0, s_rises[NS];
  int t_s_fall[NS], t_all = 0, t_sys = 0;
  logic p_mrst = 1'b1, p_all = 1'b0, p_sys = 1'b0;
  logic [NS-1:0] p_srst = '1;

  initial begin
    mst_in_stopped = 0; mst_fx_stopped = 0; slv_bad = '0;
    mst_locked = 0; slv_locked = '0;
    for (int i = 0; i < NS; i++) begin s_lat[i] = 5; s_cnt[i] = 0; s_rises[i] = 0; t_s_fall[i] = 0; end
  end

  // Behavioural unit models and edge monitors, all on the falling edge
  always @(negedge ref_clk) begin
    logic all_now;
    cyc = cyc + 1;
    if (mst_rst && !p_mrst) m_rises++;
    for (int i = 0; i < NS; i++) begin
      if (slv_rst[i] && !p_srst[i]) s_rises[i]++;
      if (!slv_rst[i] && p_srst[i]) t_s_fall[i] = cyc;
    end
    if (sys_rst_n && !p_sys) t_sys = cyc;
    p_mrst = mst_rst; p_srst = slv_rst; p_sys = sys_rst_n;
    m_cnt = mst_rst ? 0 : (m_cnt < 100000 ? m_cnt + 1 : m_cnt);
    mst_locked = !mst_rst && (m_cnt >= m_lat) && !m_kill;
    for (int i = 0; i < NS; i++) begin
      s_cnt[i] = slv_rst[i] ? 0 : (s_cnt[i] < 100000 ? s_cnt[i] + 1 : s_cnt[i]);
      slv_locked[i] = !slv_rst[i] && (s_cnt[i] >= s_lat[i]);
    end
    all_now = mst_locked && (&slv_locked);
    if (all_now && !p_all) t_all = cyc;
    p_all = all_now;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cycles(5);
    rst_n = 1'b1;
  endtask

  task automatic clear_counts();
    m_rises = 0;
    for (int i = 0; i < NS; i++) s_rises[i] = 0;
  endtask

  // master latency, slave0 latency, slave1 latency, expected sys_rst_n
  localparam int VEC[4][4] = '{
    '{5, 5, 5, 1},
    '{30, 10, 20, 1},
    '{60, 5, 5, 0},
    '{5, 5, 60, 0}
  };

  initial begin
    // Reset state (R1)
    cycles(3);
    chk(mst_rst == 1'b1, "R1 master reset during rst_n", int'(mst_rst), 1);
    chk(slv_rst == '1, "R1 slave resets during rst_n", int'(slv_rst), 3);
    chk(sys_rst_n == 1'b0, "R1 sys_rst_n during rst_n", int'(sys_rst_n), 0);

    // Vector table
    for (int v = 0; v < 4; v++) begin
      m_lat = VEC[v][0]; s_lat[0] = VEC[v][1]; s_lat[1] = VEC[v][2];
      do_reset();
      clear_counts();
      cycles(400);
      chk(int'(sys_rst_n) == VEC[v][3], "R9 sys_rst_n after bring-up", int'(sys_rst_n), VEC[v][3]);
      if (VEC[v][0] > TOUT) begin
        chk(m_rises >= 2, "R4 master retried after timeout", m_rises, 2);
        chk(slv_rst == '1, "R2 slaves held while master unlocked", int'(slv_rst), 3);
      end
      if (VEC[v][2] > TOUT)
        chk(s_rises[1] >= 2, "R4 slave retried after timeout", s_rises[1], 2);
    end

    // Staged release, hold lengths and settle delay (R2, R3, R9)
    m_lat = 20; s_lat[0] = 5; s_lat[1] = 5;
    do_reset();
    cycles(20);
    chk(slv_rst == '1, "R2 slaves held before master lock", int'(slv_rst), 3);
    cycles(300);
    chk(sys_rst_n == 1'b1, "R9 ready after staged start", int'(sys_rst_n), 1);
    chk(t_s_fall[1] - t_s_fall[0] == LONG - SHORT, "R3 hold gap between slaves",
        t_s_fall[1] - t_s_fall[0], LONG - SHORT);
    chk((t_sys - t_all >= SET + 2) && (t_sys - t_all <= SET + 6), "R9 settle delay",
        t_sys - t_all, SET + 4);

    // Master lock loss (R5)
    clear_counts();
    m_kill = 1; cycles(10);
    chk(sys_rst_n == 1'b0, "R5 sys reset on master lock loss", int'(sys_rst_n), 0);
    chk(m_rises >= 1, "R5 master reset on lock loss", m_rises, 1);
    m_kill = 0; cycles(300);
    chk(sys_rst_n == 1'b1, "R5 recovery after lock loss", int'(sys_rst_n), 1);

    // Master status: synthesized clock stopped, then input stopped (R5)
    clear_counts();
    mst_fx_stopped = 1; cycles(30);
    chk(m_rises >= 1, "R5 master reset on fx-stopped", m_rises, 1);
    chk(sys_rst_n == 1'b0, "R5 sys reset on fx-stopped", int'(sys_rst_n), 0);
    mst_fx_stopped = 0; cycles(300);
    clear_counts();
    mst_in_stopped = 1; cycles(30);
    chk(m_rises >= 1, "R5 master reset on input-stopped", m_rises, 1);
    mst_in_stopped = 0; cycles(300);
    chk(sys_rst_n == 1'b1, "R5 recovery after status fault", int'(sys_rst_n), 1);

    // Slave bad status restarts the chain (R6)
    clear_counts();
    slv_bad[0] = 1'b1; cycles(6); slv_bad[0] = 1'b0;
    cycles(4);
    chk(m_rises >= 1, "R6 master reset on slave fault", m_rises, 1);
    cycles(300);
    chk(sys_rst_n == 1'b1, "R6 recovery after slave fault", int'(sys_rst_n), 1);

    // Input clock removed and reapplied (R7, R8)
    clk_en = 0; cycles(60);
    clear_counts();
    cycles(150);
    chk(mst_rst == 1'b1, "R7 master held without input clock", int'(mst_rst), 1);
    chk(m_rises == 0, "R7 master reset steady without clock", m_rises, 0);
    chk(sys_rst_n == 1'b0, "R7 sys reset without clock", int'(sys_rst_n), 0);
    clk_en = 1; cycles(400);
    chk(sys_rst_n == 1'b1, "R8 self recovery after clock returns", int'(sys_rst_n), 1);
    chk(mst_rst == 1'b0 && slv_rst == '0, "R8 all units released", int'({mst_rst, slv_rst}), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule